// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply Array

This block is a grid of multiply-add cells that computes a vector-by-matrix product every clock. Each cell holds one weight of the matrix and keeps it for the whole compute phase. Operand words enter along the left edge, one word per row, and move to the right one cell per cycle. Partial sums start at zero on the top edge, move down one cell per cycle, and pick up one product in each cell. Each bottom-edge column then produces one element of the result.

Every cell has two weight registers: a shadow copy and an active copy. A new weight set is shifted into the shadow copies from the top, one row per cycle, through the same cell-to-cell path that links the rows. A single swap pulse then moves the whole shadow set into the active registers. The next matrix can therefore be loaded while the current one is still computing. The block skews the operand words on entry and aligns the column results on exit. The caller presents a whole operand vector in one cycle and later receives a whole result vector in one cycle, with a matching valid flag.

Top module: `ws_systolic_array`

## Requirements
- R1: While reset is active, and until the first input vector has been accepted, out_valid is 0 and c_vec is all zero. All weights reset to zero, so a vector sent before any swap yields a zero result.
- R2: Each cycle with wld_en high shifts every shadow row r down to row r+1. Shadow row 0 takes wld_data, with lane c (bits c*16 +: 16) going to column c. After ROWS load cycles, the first row loaded sits in the bottom row ROWS-1. Matrix rows are therefore loaded last row first.
- R3: Loading shadow weights without a swap has no effect on any result.
- R4: A cycle with wswap high copies every shadow weight into its active register in that single cycle. Vectors accepted after that cycle use the new set.
- R5: For an accepted vector, result lane c of c_vec (bits c*16 +: 16) equals the sum over r of lane r of a_vec (bits r*16 +: 16) times active weight (r,c).
- R6: out_valid rises exactly ROWS+COLS-1 clock edges after the edge that accepts an in_valid vector. Back-to-back vectors give back-to-back results, and every accepted vector yields exactly one result.
- R7: Products and sums are unsigned integers that wrap modulo 2^16.
- R8: The partial sum entering the top edge is zero, so no result carries anything from an earlier vector.
- R9: When wld_en and wswap are high in the same cycle, the active weights receive the shadow contents from before that cycle's shift.
- R10: Cycles with in_valid low produce no result and no out_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wld_en | input | 1 | Shift one weight row into the shadow registers |
| wld_data | input | COLS*16 | Weight row; lane c feeds column c |
| wswap | input | 1 | Copy all shadow weights to the active weights |
| in_valid | input | 1 | a_vec holds an operand vector this cycle |
| a_vec | input | ROWS*16 | Operand vector; lane r feeds row r |
| out_valid | output | 1 | c_vec holds a result vector |
| c_vec | output | COLS*16 | Result vector; lane c from column c |

## Verification
The hardest case to reach is a weight set that streams into the shadow registers while the array is still computing with the previous set, followed by a swap between two streams. If the swap lands while a vector is still partway through the grid, that vector mixes both sets. The stimulus therefore streams vectors on every cycle while it loads the next matrix. It then leaves exactly ROWS+COLS-3 idle cycles and issues the swap on the next cycle, so the last old vector has left the grid just before the swap takes effect. It then streams again at once. A further case raises load and swap in the same cycle to confirm that the active set takes the contents from before the shift.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  localparam int WSA_DW   = 16;
  localparam int WSA_ROWS = 4;
  localparam int WSA_COLS = 4;
endpackage

// File: rtl/wsa_delay.sv
// Fixed-depth register delay line, DEPTH >= 1.
module wsa_delay #(
  parameter int DW    = 16,
  parameter int DEPTH = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/wsa_pe.sv
// One cell: registered multiply-add on the passing partial sum,
// shadow weight on the load chain, active weight used for products.
module wsa_pe #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] ps_i,
  input  logic [DW-1:0] wsh_i,
  input  logic          wld_en,
  input  logic          wswap,
  output logic [DW-1:0] ps_o,
  output logic [DW-1:0] wsh_o,
  output logic [DW-1:0] wact_o
);
  logic [DW-1:0] ps_q, ps_d;
  logic [DW-1:0] wsh_q, wsh_d;
  logic [DW-1:0] wact_q, wact_d;

  always_comb begin
    ps_d   = ps_i + a_i * wact_q;
    wsh_d  = wsh_i;
    wact_d = wsh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      wsh_q  <= '0;
      wact_q <= '0;
    end else begin
      ps_q <= ps_d;
      if (wld_en) wsh_q  <= wsh_d;
      if (wswap)  wact_q <= wact_d;
    end
  end

  assign ps_o   = ps_q;
  assign wsh_o  = wsh_q;
  assign wact_o = wact_q;
endmodule

// File: rtl/ws_systolic_array.sv
module ws_systolic_array
  import wsa_pkg::*;
#(
  parameter int ROWS = WSA_ROWS,
  parameter int COLS = WSA_COLS,
  parameter int DW   = WSA_DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wld_en,
  input  logic [COLS*DW-1:0] wld_data,
  input  logic               wswap,
  input  logic               in_valid,
  input  logic [ROWS*DW-1:0] a_vec,
  output logic               out_valid,
  output logic [COLS*DW-1:0] c_vec
);
  localparam int LAT = ROWS + COLS - 1;
  localparam int WB  = ROWS * COLS * DW;

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [DW-1:0] a_h  [ROWS][COLS];
  logic [DW-1:0] ps_v [ROWS+1][COLS];
  logic [WB-1:0] w_shadow;
  logic [WB-1:0] w_active;

  genvar r, c;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      // Row r operand is held back r cycles to meet its partial sums.
      if (r == 0) begin : g_noskew
        assign a_h[r][0] = a_vec[r*DW +: DW];
      end else begin : g_skew
        wsa_delay #(.DW(DW), .DEPTH(r)) u_skew (
          .clk(clk), .rst_n(rst_sync_n),
          .d(a_vec[r*DW +: DW]), .q(a_h[r][0])
        );
      end
      for (c = 1; c < COLS; c++) begin : g_hop
        wsa_delay #(.DW(DW), .DEPTH(1)) u_hop (
          .clk(clk), .rst_n(rst_sync_n),
          .d(a_h[r][c-1]), .q(a_h[r][c])
        );
      end
    end

    for (c = 0; c < COLS; c++) begin : g_top
      assign ps_v[0][c] = '0;
    end

    for (r = 0; r < ROWS; r++) begin : g_pr
      for (c = 0; c < COLS; c++) begin : g_pc
        logic [DW-1:0] wsh_in;
        if (r == 0) begin : g_wsrc_edge
          assign wsh_in = wld_data[c*DW +: DW];
        end else begin : g_wsrc_up
          assign wsh_in = w_shadow[((r-1)*COLS + c)*DW +: DW];
        end
        wsa_pe #(.DW(DW)) u_pe (
          .clk(clk), .rst_n(rst_sync_n),
          .a_i(a_h[r][c]), .ps_i(ps_v[r][c]), .wsh_i(wsh_in),
          .wld_en(wld_en), .wswap(wswap),
          .ps_o(ps_v[r+1][c]),
          .wsh_o(w_shadow[(r*COLS + c)*DW +: DW]),
          .wact_o(w_active[(r*COLS + c)*DW +: DW])
        );
      end
    end

    // Column c leaves the grid c cycles late; pad the rest to line up.
    for (c = 0; c < COLS; c++) begin : g_out
      if (c == COLS - 1) begin : g_nodesk
        assign c_vec[c*DW +: DW] = ps_v[ROWS][c];
      end else begin : g_desk
        wsa_delay #(.DW(DW), .DEPTH(COLS - 1 - c)) u_desk (
          .clk(clk), .rst_n(rst_sync_n),
          .d(ps_v[ROWS][c]), .q(c_vec[c*DW +: DW])
        );
      end
    end
  endgenerate

  wsa_delay #(.DW(1), .DEPTH(LAT)) u_vld (
    .clk(clk), .rst_n(rst_sync_n), .d(in_valid), .q(out_valid)
  );
endmodule

// File: rtl/wsa_checker.sv
module wsa_checker #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wld_en,
  input logic [COLS*DW-1:0]      wld_data,
  input logic                    wswap,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic [ROWS*COLS*DW-1:0] w_shadow,
  input logic [ROWS*COLS*DW-1:0] w_active
);
  localparam int LAT = ROWS + COLS - 1;
  localparam int RW  = COLS * DW;

  logic [15:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + 16'(in_valid) - 16'(out_valid);
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R1: assert (!out_valid);
  end

  assert_load_row0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wld_en |=> w_shadow[RW-1:0] == $past(wld_data));

  generate
    if (ROWS > 1) begin : g_shift
      assert_load_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wld_en |=> w_shadow[ROWS*RW-1:RW] == $past(w_shadow[(ROWS-1)*RW-1:0]));
    end
  endgenerate

  assert_shadow_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wld_en |=> $stable(w_shadow));

  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wswap |=> $stable(w_active));

  assert_swap_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wswap |=> w_active == $past(w_shadow));

  assert_swap_during_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wswap && wld_en) |=> w_active == $past(w_shadow));

  assert_inflight_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 16'(LAT));

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 16'd0);
endmodule

bind ws_systolic_array wsa_checker #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wld_en(wld_en), .wld_data(wld_data),
  .wswap(wswap), .in_valid(in_valid), .out_valid(out_valid),
  .w_shadow(w_shadow), .w_active(w_active)
);

// File: tb/sim_ws_systolic_array.sv
module sim_ws_systolic_array;
  localparam int R   = 4;
  localparam int C   = 4;
  localparam int DW  = 16;
  localparam int LAT = R + C - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wld_en;
  logic [C*DW-1:0]  wld_data;
  logic             wswap;
  logic             in_valid;
  logic [R*DW-1:0]  a_vec;
  logic             out_valid;
  logic [C*DW-1:0]  c_vec;

  ws_systolic_array #(.ROWS(R), .COLS(C), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wld_en(wld_en), .wld_data(wld_data),
    .wswap(wswap), .in_valid(in_valid), .a_vec(a_vec),
    .out_valid(out_valid), .c_vec(c_vec)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int wr_i  = 0;
  int rd_i  = 0;
  bit mon_en = 1'b0;

  logic [DW-1:0]   m_shd [R][C];
  logic [DW-1:0]   m_act [R][C];
  logic [C*DW-1:0] exp_v   [1024];
  int              exp_cyc [1024];
  string           exp_tag [1024];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [C*DW-1:0] act, input logic [C*DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Result monitor: data per R5 (with scenario tag), latency per R6.
  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      if (rd_i < wr_i) begin
        check(c_vec === exp_v[rd_i], exp_tag[rd_i], "result", c_vec, exp_v[rd_i]);
        check(cyc - exp_cyc[rd_i] == LAT, "R6", "latency",
              (C*DW)'(cyc - exp_cyc[rd_i]), (C*DW)'(LAT));
        rd_i++;
      end else begin
        check(1'b0, "R10", "out_valid with nothing pending", '1, '0);
      end
    end
  end

  // One clock of stimulus; the bench model follows R2, R4, R5, R7, R9.
  task automatic step(input bit ld, input logic [C*DW-1:0] wd, input bit sw,
                      input bit v, input logic [R*DW-1:0] av, input string tag);
    wld_en = ld; wld_data = wd; wswap = sw; in_valid = v; a_vec = av;
    if (v) begin
      logic [C*DW-1:0] e;
      for (int c = 0; c < C; c++) begin
        logic [DW-1:0] s;
        s = '0;
        for (int r = 0; r < R; r++) s = s + av[r*DW +: DW] * m_act[r][c];
        e[c*DW +: DW] = s;
      end
      exp_v[wr_i] = e; exp_cyc[wr_i] = cyc; exp_tag[wr_i] = tag;
      wr_i++;
    end
    if (sw) for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) m_act[r][c] = m_shd[r][c];
    if (ld) begin
      for (int r = R - 1; r > 0; r--) for (int c = 0; c < C; c++) m_shd[r][c] = m_shd[r-1][c];
      for (int c = 0; c < C; c++) m_shd[0][c] = wd[c*DW +: DW];
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0, "");
  endtask

  function automatic logic [R*DW-1:0] rnd_vec();
    logic [R*DW-1:0] v;
    for (int i = 0; i < R; i++) v[i*DW +: DW] = DW'($urandom_range(0, 65535));
    return v;
  endfunction

  // Matrix row k of a random set, loaded last row first (R2).
  task automatic load_matrix(input logic [DW-1:0] w [R][C], input bit with_vecs,
                             input string tag);
    for (int k = 0; k < R; k++) begin
      logic [C*DW-1:0] row;
      for (int c = 0; c < C; c++) row[c*DW +: DW] = w[R-1-k][c];
      step(1, row, 0, with_vecs, with_vecs ? rnd_vec() : '0, tag);
    end
  endtask

  task automatic drain_check(input string req);
    idle(LAT + 3);
    check(rd_i == wr_i, req, "all results delivered", (C*DW)'(rd_i), (C*DW)'(wr_i));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wld_en = 0; wld_data = '0; wswap = 0; in_valid = 0; a_vec = '0;
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) begin
      m_shd[r][c] = '0; m_act[r][c] = '0;
    end
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid in reset", (C*DW)'(out_valid), '0);
    check(c_vec === '0, "R1", "c_vec in reset", c_vec, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid after release", (C*DW)'(out_valid), '0);
    check(c_vec === '0, "R1", "c_vec after release", c_vec, '0);
    mon_en = 1'b1;
  endtask

  task automatic t_zero_weights();
    step(0, '0, 0, 1, rnd_vec(), "R1 zero weights");
    step(0, '0, 0, 1, {R{16'hFFFF}}, "R1 zero weights");
    drain_check("R1");
  endtask

  task automatic t_basic();
    logic [DW-1:0] w [R][C];
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) w[r][c] = DW'(r * C + c + 1);
    load_matrix(w, 0, "");
    step(0, '0, 1, 0, '0, "");
    step(0, '0, 0, 1, {16'd4, 16'd3, 16'd2, 16'd1}, "R2 R4 R5 basic");
    step(0, '0, 0, 1, {16'd0, 16'd0, 16'd0, 16'd1}, "R2 row0 only");
    step(0, '0, 0, 1, {16'd1, 16'd0, 16'd0, 16'd0}, "R2 row3 only");
    drain_check("R6");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 24; i++) step(0, '0, 0, 1, rnd_vec(), "R5 R8 stream");
    drain_check("R6");
  endtask

  task automatic t_overlap_swap();
    logic [DW-1:0] w [R][C];
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) w[r][c] = DW'($urandom_range(0, 65535));
    for (int i = 0; i < 3; i++) step(0, '0, 0, 1, rnd_vec(), "R3 before load");
    load_matrix(w, 1, "R3 during load");
    for (int i = 0; i < 3; i++) step(0, '0, 0, 1, rnd_vec(), "R3 after load");
    idle(R + C - 3);
    step(0, '0, 1, 0, '0, "");
    for (int i = 0; i < 10; i++) step(0, '0, 0, 1, rnd_vec(), "R4 after swap");
    drain_check("R4");
  endtask

  task automatic t_swap_with_load();
    logic [DW-1:0] w [R][C];
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) w[r][c] = DW'($urandom_range(0, 65535));
    load_matrix(w, 0, "");
    step(1, {C{16'hA5A5}}, 1, 0, '0, "");
    for (int i = 0; i < 6; i++) step(0, '0, 0, 1, rnd_vec(), "R9 swap with load");
    drain_check("R9");
  endtask

  task automatic t_wrap();
    logic [DW-1:0] w [R][C];
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++)
      w[r][c] = (c == 0) ? 16'hFFFF : (c == 1) ? 16'h8000 : 16'h7FFF;
    load_matrix(w, 0, "");
    step(0, '0, 1, 0, '0, "");
    step(0, '0, 0, 1, {R{16'hFFFF}}, "R7 wrap all ones");
    step(0, '0, 0, 1, {R{16'h0002}}, "R7 wrap to zero");
    step(0, '0, 0, 1, {16'hFFFF, 16'h1234, 16'h8001, 16'h4000}, "R7 wrap mixed");
    drain_check("R7");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 6; i++) begin
      step(0, '0, 0, 1, rnd_vec(), "R10 sparse");
      idle(i % 3 + 1);
    end
    drain_check("R10");
  endtask

  initial begin
    t_reset();
    t_zero_weights();
    t_basic();
    t_stream();
    t_overlap_swap();
    t_swap_with_load();
    t_wrap();
    t_gaps();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule